// File: doc/BRIEF.md
# Two-Rate Three-Color Packet Meter

This block meters one ingress traffic profile. It keeps two token buckets: a committed bucket and a peak bucket. A free-running timebase refills both buckets at a programmable interval. Each packet descriptor that arrives carries a length. The meter works out a token cost for that packet, compares the cost with the contents of the two buckets, and returns a color together with the 2-bit action configured for that color.

Every rate, every burst cap and the per-packet adjustment use the same floating encoding: the value is (1 + m/256) · 2^e tokens. A token is one byte, or one packet in packet-count mode. Token counts are held in fixed point with 8 fractional bits, so the smallest possible cost of 1/256 token can be represented. A bucket whose exponent is 24 or more is switched off. It gains nothing and holds nothing, so with the peak bucket switched off the meter returns only green or red. The meter is always color-blind: the color of an arriving packet plays no part in the decision.

Configuration arrives on plain input ports and is sampled on every cycle. One result is produced per accepted packet, one cycle after the packet.

Top module: `tr3c_meter`

## Requirements
- R1: In reset, and after it, out_valid is low and both buckets hold zero tokens. A packet sent before the first refill is therefore red.
- R2: A refill occurs once every 2·CLK_MHZ cycles × 2^rdiv. On a refill each bucket gains (256+mant)·2^exp in units of 1/256 token.
- R3: After a refill a bucket never holds more than its cap, which is (256+mant)·2^exp units taken from its burst fields.
- R4: A bucket whose rate or cap exponent is 24 or more adds zero tokens or has a cap of zero. With the peak bucket off, no packet is yellow.
- R5: In byte mode (len_mode=0) the cost is 256·(pkt_len − len_ofs) + (adj_mant − 256)·2^adj_exp units.
- R6: With len_mode=1, adj_mant=384 and adj_exp=1, every packet costs exactly one token (256 units).
- R7: The cost is never below 1 unit (1/256 token). A cost that works out negative or zero is raised to 1.
- R8: A packet is green when the committed bucket covers its cost. The committed bucket is then debited, and so is the peak bucket, which stops at zero.
- R9: A packet is yellow when only the peak bucket covers its cost. Only the peak bucket is debited.
- R10: A red packet debits neither bucket.
- R11: out_action equals the 2-bit action of the color given: act_green, act_yellow or act_red. Code 0 means pass and code 1 means drop.
- R12: When a refill and a packet fall in the same cycle, the refill is applied first and the packet is judged against the refilled level.
- R13: out_valid rises exactly one cycle after each pkt_valid and at no other time. out_color is coded green=0, yellow=1, red=2 and never 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_valid | input | 1 | A packet descriptor is present this cycle |
| pkt_len | input | LEN_W | Packet length in bytes |
| cir_mant | input | 8 | Committed refill mantissa |
| cir_exp | input | 5 | Committed refill exponent |
| cbs_mant | input | 8 | Committed cap mantissa |
| cbs_exp | input | 5 | Committed cap exponent |
| pir_mant | input | 8 | Peak refill mantissa |
| pir_exp | input | 5 | Peak refill exponent |
| pbs_mant | input | 8 | Peak cap mantissa |
| pbs_exp | input | 5 | Peak cap exponent |
| rdiv | input | RDIV_W | Refill interval is 2^rdiv timebase units |
| len_mode | input | 1 | 1 = the length term is zero (packet-count mode) |
| len_ofs | input | PTR_W | Byte offset subtracted from the length |
| adj_mant | input | 9 | Cost adjustment mantissa |
| adj_exp | input | 5 | Cost adjustment exponent |
| act_green | input | 2 | Action for green |
| act_yellow | input | 2 | Action for yellow |
| act_red | input | 2 | Action for red |
| out_valid | output | 1 | A result is present |
| out_color | output | 2 | Color of the result |
| out_action | output | 2 | Action of the result |

## Verification
The action properties compare out_action with the action inputs as they stood in the cycle of the packet. They therefore assume nothing about how stable the configuration is. The debit property assumes that the committed level can fall outside a refill edge only through a packet. This holds because lowering a cap takes effect only when a refill is applied. The stimulus changes configuration only between packets and uses exponents no larger than 24. It lines up packets against refill edges by watching the bench's own timebase counter, so that the cases where a refill and a packet coincide, and the bursts that run without a refill, both land where they are meant to.

// File: rtl/mtr_pkg.sv
// Shared constants, types and the floating-value decoder used by the meter.
// Assumes an 8-bit mantissa and a 5-bit exponent; exponent >= EXP_OFF means "off".
package mtr_pkg;
    localparam int MANT_W  = 8;
    localparam int EXP_W   = 5;
    localparam int FRAC_W  = 8;
    localparam int EXP_OFF = 24;
    localparam int ACC_W   = MANT_W + 1 + EXP_OFF;

    typedef enum logic [1:0] {
        CLR_GREEN  = 2'd0,
        CLR_YELLOW = 2'd1,
        CLR_RED    = 2'd2
    } color_e;

    // Decode (1+m/256)*2^e tokens into 1/256-token units.
    function automatic logic [ACC_W-1:0] fval(input logic [MANT_W-1:0] m,
                                              input logic [EXP_W-1:0] e);
        if (int'(e) >= EXP_OFF) return '0;
        return ACC_W'({1'b1, m}) << e;
    endfunction
endpackage

// File: rtl/mtr_timebase.sv
// Refill timebase: a 2 us prescaler from CLK_MHZ, followed by a 2^rdiv divider.
// Assumes CLK_MHZ >= 1. refill pulses for one cycle at the end of each interval.
module mtr_timebase #(
    parameter int CLK_MHZ = 50,
    parameter int RDIV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RDIV_W-1:0] rdiv,
    output logic              refill
);
    localparam int TICK_CYC = 2 * CLK_MHZ;
    localparam int PRE_W    = $clog2(TICK_CYC + 1);
    localparam int DIV_W    = 2 ** RDIV_W;

    logic [PRE_W-1:0] pre_q;
    logic [DIV_W-1:0] div_q;
    logic             unit;
    logic [DIV_W-1:0] lim;

    // Unit pulse, and the divider limit for the selected interval.
    always_comb begin
        unit   = (pre_q == PRE_W'(TICK_CYC - 1));
        lim    = (DIV_W'(1) << rdiv) - DIV_W'(1);
        refill = unit && (div_q >= lim);
    end

    // Prescaler and divider counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            div_q <= '0;
        end else begin
            pre_q <= unit ? '0 : pre_q + PRE_W'(1);
            if (unit) div_q <= refill ? '0 : div_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/mtr_cost.sv
// Per-packet token cost in 1/256-token units, with a floor of 1 and a ceiling at the accumulator maximum.
// Purely combinational; assumes pkt_len and len_ofs are byte counts.
module mtr_cost
    import mtr_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int PTR_W = 8
) (
    input  logic             len_mode,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic [PTR_W-1:0] len_ofs,
    input  logic [8:0]       adj_mant,
    input  logic [EXP_W-1:0] adj_exp,
    output logic [ACC_W-1:0] cost
);
    localparam int SUM_W = ACC_W + LEN_W + FRAC_W;
    localparam logic signed [SUM_W-1:0] CMAX = SUM_W'({ACC_W{1'b1}});

    logic signed [SUM_W-1:0] len_term, adj_term, sum;

    // Signed cost, then clamped into [1, CMAX].
    always_comb begin
        len_term = len_mode ? '0
                 : (SUM_W'(pkt_len) - SUM_W'(len_ofs)) <<< FRAC_W;
        adj_term = (SUM_W'(adj_mant) - SUM_W'(256)) <<< adj_exp;
        sum      = len_term + adj_term;
        if (sum < 1)          cost = ACC_W'(1);
        else if (sum > CMAX)  cost = {ACC_W{1'b1}};
        else                  cost = sum[ACC_W-1:0];
    end
endmodule

// File: rtl/mtr_bucket.sv
// One token bucket: refill up to the cap, then an optional debit that stops at zero.
// level_pre is the level after this cycle's refill and before any debit.
module mtr_bucket
    import mtr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              refill,
    input  logic [MANT_W-1:0] rate_m,
    input  logic [EXP_W-1:0]  rate_e,
    input  logic [MANT_W-1:0] cap_m,
    input  logic [EXP_W-1:0]  cap_e,
    input  logic              take,
    input  logic [ACC_W-1:0]  amt,
    output logic [ACC_W-1:0]  level_pre,
    output logic [ACC_W-1:0]  level
);
    logic [ACC_W-1:0] capv;
    logic [ACC_W:0]   grown;

    // Refill first, with the result limited to the cap.
    always_comb begin
        capv  = fval(cap_m, cap_e);
        grown = {1'b0, level} + {1'b0, fval(rate_m, rate_e)};
        if (!refill)                  level_pre = level;
        else if (grown > {1'b0, capv}) level_pre = capv;
        else                          level_pre = grown[ACC_W-1:0];
    end

    // Level register with a debit that stops at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      level <= '0;
        else if (take)   level <= (level_pre >= amt) ? level_pre - amt : '0;
        else             level <= level_pre;
    end
endmodule

// File: rtl/tr3c_meter.sv
// Two-rate three-color meter for a single profile, color-blind.
// Each cycle: refill (if due), then judge any packet against the refilled levels.
// One registered result per packet, one cycle later. Assumes configuration is held between packets.
module tr3c_meter
    import mtr_pkg::*;
#(
    parameter int CLK_MHZ = 50,
    parameter int LEN_W   = 16,
    parameter int PTR_W   = 8,
    parameter int RDIV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic [7:0]        cir_mant,
    input  logic [4:0]        cir_exp,
    input  logic [7:0]        cbs_mant,
    input  logic [4:0]        cbs_exp,
    input  logic [7:0]        pir_mant,
    input  logic [4:0]        pir_exp,
    input  logic [7:0]        pbs_mant,
    input  logic [4:0]        pbs_exp,
    input  logic [RDIV_W-1:0] rdiv,
    input  logic              len_mode,
    input  logic [PTR_W-1:0]  len_ofs,
    input  logic [8:0]        adj_mant,
    input  logic [4:0]        adj_exp,
    input  logic [1:0]        act_green,
    input  logic [1:0]        act_yellow,
    input  logic [1:0]        act_red,
    output logic              out_valid,
    output logic [1:0]        out_color,
    output logic [1:0]        out_action
);
    logic             refill_w;
    logic [ACC_W-1:0] cost, c_pre, c_level, p_pre, p_level;
    logic             hit_c, hit_p, take_c, take_p;
    color_e           col;

    mtr_timebase #(.CLK_MHZ(CLK_MHZ), .RDIV_W(RDIV_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .rdiv(rdiv), .refill(refill_w));

    mtr_cost #(.LEN_W(LEN_W), .PTR_W(PTR_W)) u_cost (
        .len_mode(len_mode), .pkt_len(pkt_len), .len_ofs(len_ofs),
        .adj_mant(adj_mant), .adj_exp(adj_exp), .cost(cost));

    mtr_bucket u_cbkt (
        .clk(clk), .rst_n(rst_n), .refill(refill_w),
        .rate_m(cir_mant), .rate_e(cir_exp), .cap_m(cbs_mant), .cap_e(cbs_exp),
        .take(take_c), .amt(cost), .level_pre(c_pre), .level(c_level));

    mtr_bucket u_pbkt (
        .clk(clk), .rst_n(rst_n), .refill(refill_w),
        .rate_m(pir_mant), .rate_e(pir_exp), .cap_m(pbs_mant), .cap_e(pbs_exp),
        .take(take_p), .amt(cost), .level_pre(p_pre), .level(p_level));

    // Color decision against the refilled levels.
    always_comb begin
        hit_c  = (c_pre >= cost);
        hit_p  = (p_pre >= cost);
        take_c = pkt_valid && hit_c;
        take_p = pkt_valid && (hit_c || hit_p);
        if (hit_c)      col = CLR_GREEN;
        else if (hit_p) col = CLR_YELLOW;
        else            col = CLR_RED;
    end

    // Registered result with the action for the chosen color.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_color  <= CLR_GREEN;
            out_action <= 2'd0;
        end else begin
            out_valid <= pkt_valid;
            if (pkt_valid) begin
                out_color <= col;
                unique case (col)
                    CLR_GREEN:  out_action <= act_green;
                    CLR_YELLOW: out_action <= act_yellow;
                    default:    out_action <= act_red;
                endcase
            end
        end
    end
endmodule

// File: rtl/tr3c_meter_chk.sv
// Property checker for tr3c_meter, bound into every instance of it.
module tr3c_meter_chk #(
    parameter int ACC_W = 33
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pkt_valid,
    input logic             out_valid,
    input logic [1:0]       out_color,
    input logic [1:0]       out_action,
    input logic [1:0]       act_green,
    input logic [1:0]       act_yellow,
    input logic [1:0]       act_red,
    input logic             refill,
    input logic [ACC_W-1:0] c_level
);
    // R13
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> out_valid);
    // R13
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |=> !out_valid);
    // R13
    color_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_color != 2'd3));
    // R11
    act_green_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_color == 2'd0) |-> (out_action == $past(act_green)));
    // R11
    act_yellow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_color == 2'd1) |-> (out_action == $past(act_yellow)));
    // R11
    act_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_color == 2'd2) |-> (out_action == $past(act_red)));
    // R10
    debit_needs_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(refill) && (c_level < $past(c_level))) |-> $past(pkt_valid));
endmodule

bind tr3c_meter tr3c_meter_chk #(.ACC_W(mtr_pkg::ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid),
    .out_valid(out_valid), .out_color(out_color), .out_action(out_action),
    .act_green(act_green), .act_yellow(act_yellow), .act_red(act_red),
    .refill(refill_w), .c_level(c_level));

// File: tb/tr3c_meter_tb.sv
module tr3c_meter_tb;
    localparam int CLK_MHZ = 50;
    localparam int TICK    = 2 * CLK_MHZ;
    localparam longint CMAXL = (64'd1 << 33) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pkt_valid = 1'b0;
    logic [15:0] pkt_len = '0;
    logic [7:0] cir_mant = '0, cbs_mant = '0, pir_mant = '0, pbs_mant = '0;
    logic [4:0] cir_exp = 5'd24, cbs_exp = 5'd24, pir_exp = 5'd24, pbs_exp = 5'd24;
    logic [3:0] rdiv = '0;
    logic len_mode = 1'b0;
    logic [7:0] len_ofs = '0;
    logic [8:0] adj_mant = 9'd256;
    logic [4:0] adj_exp = '0;
    logic [1:0] act_green = 2'd0, act_yellow = 2'd0, act_red = 2'd1;
    logic out_valid;
    logic [1:0] out_color, out_action;

    always #10 clk = ~clk;

    tr3c_meter #(.CLK_MHZ(CLK_MHZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
        .cir_mant(cir_mant), .cir_exp(cir_exp), .cbs_mant(cbs_mant), .cbs_exp(cbs_exp),
        .pir_mant(pir_mant), .pir_exp(pir_exp), .pbs_mant(pbs_mant), .pbs_exp(pbs_exp),
        .rdiv(rdiv), .len_mode(len_mode), .len_ofs(len_ofs),
        .adj_mant(adj_mant), .adj_exp(adj_exp),
        .act_green(act_green), .act_yellow(act_yellow), .act_red(act_red),
        .out_valid(out_valid), .out_color(out_color), .out_action(out_action));

    int checks = 0, fails = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // Reference model state
    int m_pre = 0, m_dv = 0;
    longint m_cl = 0, m_pl = 0;
    bit m_ov = 0, m_ref = 0;
    int m_oc = 0, m_oa = 0;

    function automatic longint fv(input int m, input int e);
        if (e >= 24) return 0;
        return longint'(256 + m) <<< e;
    endfunction

    function automatic longint pcost();
        longint s;
        s = (len_mode ? 0 : (longint'(pkt_len) - longint'(len_ofs)) * 256)
          + (longint'(adj_mant) - 256) * (longint'(1) <<< adj_exp);
        if (s < 1) return 1;
        if (s > CMAXL) return CMAXL;
        return s;
    endfunction

    task automatic model_step();
        longint c, cap;
        if (!rst_n) begin
            m_pre = 0; m_dv = 0; m_cl = 0; m_pl = 0; m_ov = 0; m_ref = 0;
            return;
        end
        m_ref = (m_pre == TICK - 1) && (m_dv >= (1 << rdiv) - 1);
        if (m_pre == TICK - 1) begin
            m_pre = 0;
            m_dv = m_ref ? 0 : m_dv + 1;
        end else m_pre = m_pre + 1;
        if (m_ref) begin
            cap = fv(cbs_mant, cbs_exp);
            m_cl = (m_cl + fv(cir_mant, cir_exp) > cap) ? cap : m_cl + fv(cir_mant, cir_exp);
            cap = fv(pbs_mant, pbs_exp);
            m_pl = (m_pl + fv(pir_mant, pir_exp) > cap) ? cap : m_pl + fv(pir_mant, pir_exp);
        end
        m_ov = pkt_valid;
        if (pkt_valid) begin
            c = pcost();
            if (m_cl >= c) begin
                m_cl -= c; m_pl = (m_pl >= c) ? m_pl - c : 0; m_oc = 0; m_oa = act_green;
            end else if (m_pl >= c) begin
                m_pl -= c; m_oc = 1; m_oa = act_yellow;
            end else begin
                m_oc = 2; m_oa = act_red;
            end
        end
    endtask

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: advance the model, take the edge, compare away from the edge.
    task automatic cyc();
        model_step();
        @(posedge clk);
        #1;
        chk(out_valid == m_ov, {cur_req, " valid"}, out_valid, m_ov);
        if (m_ov && out_valid) begin
            chk(int'(out_color) == m_oc, {cur_req, " color"}, out_color, m_oc);
            chk(int'(out_action) == m_oa, {cur_req, " action"}, out_action, m_oa);
        end
    endtask

    task automatic send(input int len);
        pkt_valid = 1'b1; pkt_len = 16'(len);
        cyc();
        pkt_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wait_refill();
        do cyc(); while (!m_ref);
    endtask

    initial begin
        int greens, yellows;
        // R1: reset state
        idle(3);
        chk(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
        rst_n = 1'b1;
        // R2 / R4: committed 256 tok/refill, cap 1024 tok, peak off
        cir_mant = 0; cir_exp = 8; cbs_mant = 0; cbs_exp = 10;
        send(10);
        chk(out_color == 2'd2, "R1 empty red", out_color, 2);
        chk(out_action == 2'd1, "R11 red drop", out_action, 1);
        // R12: packet in the refill cycle
        cur_req = "R12";
        while (m_pre != TICK - 1) cyc();
        send(100);
        chk(out_color == 2'd0, "R12 refill first", out_color, 0);
        // R3: many refills clamp at 1024 tokens
        cur_req = "R3";
        idle(1200);
        wait_refill();
        send(1024);
        chk(out_color == 2'd0, "R3 full cap green", out_color, 0);
        send(1);
        chk(out_color == 2'd2, "R3 clamp red (R4 no yellow)", out_color, 2);
        // R5 and R10: cost 257 tokens against 256, then 256 tokens
        cur_req = "R5";
        cbs_exp = 8;
        wait_refill();
        len_ofs = 44; adj_mant = 320; adj_exp = 2;
        send(300);
        chk(out_color == 2'd2, "R5 byte cost red", out_color, 2);
        len_ofs = 45;
        send(300);
        chk(out_color == 2'd0, "R10 red left level", out_color, 0);
        len_ofs = 0; adj_mant = 256; adj_exp = 0;
        // R6: packet-count mode, cap 4 tokens
        cur_req = "R6";
        len_mode = 1; adj_mant = 384; adj_exp = 1;
        cir_exp = 1; cbs_exp = 2;
        idle(500);
        wait_refill();
        greens = 0;
        for (int i = 0; i < 6; i++) begin
            send(1500);
            if (out_color == 2'd0) greens++;
        end
        chk(greens == 4, "R6 packet count", greens, 4);
        // R7: cost floor of 1/256 token, 1 token cap
        cur_req = "R7";
        adj_mant = 0; adj_exp = 0; cir_exp = 0; cbs_exp = 0; rdiv = 4;
        wait_refill();
        greens = 0;
        for (int i = 0; i < 257; i++) begin
            send(64);
            if (out_color == 2'd0) greens++;
        end
        chk(greens == 256, "R7 min cost", greens, 256);
        // R8 / R9 / R11: both buckets active, non-default actions
        cur_req = "R9";
        rdiv = 0; len_mode = 0; adj_mant = 256; adj_exp = 0;
        cir_exp = 6; cbs_exp = 7; pir_exp = 9; pbs_exp = 11;
        act_green = 2'd2; act_yellow = 2'd3; act_red = 2'd0;
        greens = 0; yellows = 0;
        for (int i = 0; i < 900; i++) begin
            if (i % 3 == 0) begin
                send(40 + (i * 37) % 300);
                if (out_color == 2'd0) greens++;
                if (out_color == 2'd1) yellows++;
            end else cyc();
        end
        chk(yellows > 0, "R9 yellow seen", yellows, 1);
        chk(greens > 0, "R8 green seen", greens, 1);
        // R13 / R2: mixed pattern with an offset and a slower interval
        cur_req = "R13";
        rdiv = 1; len_ofs = 20; cir_mant = 128; pir_mant = 64;
        for (int i = 0; i < 1500; i++) begin
            if ((i * 7) % 5 < 2) send(30 + (i * 53) % 700);
            else cyc();
        end
        cur_req = "R2";
        idle(400);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule